// File: doc/BRIEF.md
# Configurable DMA Channel Engine

This block is one DMA channel that copies items from a source address to a destination address over a shared memory port. Software places a configuration on the `cfg_*` inputs and pulses `arm_i`. The channel samples the configuration and raises `armed_o`. It then waits for a start, which is either a pulse on `trig_i` or the pending software request flag. Each item takes two phases on the port. The read phase holds `mem_req_o` high with `mem_we_o` low until `mem_gnt_i` is seen, and the read data is taken in that grant cycle. The write phase holds `mem_req_o` and `mem_we_o` high until the next grant.

The transfer mode decides how much one start moves. Single modes move one item per start. Block modes move every remaining item. When the last item is written, a repeated mode restores the working addresses and count and stays armed, and a non-repeated mode disarms. In both cases a one-cycle completion interrupt is raised if it is enabled.

In variable-length operation the first item read gives the number of further items to move. That length item is itself copied to the destination. For word items, 13 bits of the length are used. For byte items, either 7 or 8 bits are used.

Top module: `dma_chan`

## Requirements
- R1: After reset, `armed_o`, `mem_req_o`, `irq_o` and `sw_req_o` are all 0.
- R2: A pulse on `arm_i` while the channel is idle samples the whole configuration and sets `armed_o`. While disarmed, `trig_i` pulses are ignored and are not remembered.
- R3: Each item is read at the source address (`mem_we_o`=0) and then written at the destination address (`mem_we_o`=1) with the data read. Request, direction and address hold steady until `mem_gnt_i`.
- R4: `cfg_word_i`=1 moves 16-bit items with `mem_word_o`=1. Byte items use `mem_rdata_i[7:0]` and write `mem_wdata_o` with its upper byte zero.
- R5: Each address steps after every written item by the item size (1 for a byte, 2 for a word). The step code is 0 for hold, 1 for increment, 2 for decrement and 3 for hold, and each address has its own code.
- R6: `cfg_mode_i` is encoded as 0 single, 1 block, 2 repeated single and 3 repeated block. In single modes each start moves exactly one item.
- R7: In block modes one start moves all remaining items. Triggers that arrive while a block is in progress are ignored.
- R8: With a fixed length, the channel completes after `cfg_len_i` items, and a length of 0 moves one item. A non-repeated mode clears `armed_o` on completion.
- R9: A repeated mode stays armed on completion, and the next start begins again at the sampled source address, destination address and count.
- R10: On completion, `irq_o` is high for exactly the one cycle after the final write grant, and only if `cfg_irq_en_i` was set at arming.
- R11: With `cfg_vlen_i`=1, the first item read gives a length L, and L+1 items are moved including the length item. For word items, L is bits 12:0 of that word, and L=0 moves only the length item.
- R12: For byte items in variable-length mode, `cfg_len8_i`=1 takes L from bits 7:0 and `cfg_len8_i`=0 takes it from bits 6:0.
- R13: A pulse on `sw_req_set_i` sets `sw_req_o`, which acts as a start and clears once a start is accepted. The flag stays pending while the channel is disarmed. If it is set again in the cycle a start is accepted, it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_src_i | input | AW | Source start address |
| cfg_dst_i | input | AW | Destination start address |
| cfg_len_i | input | CW | Fixed item count |
| cfg_src_step_i | input | 2 | Source step code |
| cfg_dst_step_i | input | 2 | Destination step code |
| cfg_word_i | input | 1 | 1 = 16-bit items, 0 = bytes |
| cfg_mode_i | input | 2 | Transfer mode |
| cfg_vlen_i | input | 1 | Take length from first item |
| cfg_len8_i | input | 1 | Byte length uses 8 bits (else 7) |
| cfg_irq_en_i | input | 1 | Completion interrupt enable |
| arm_i | input | 1 | Arm pulse, samples configuration |
| trig_i | input | 1 | Hardware start pulse |
| sw_req_set_i | input | 1 | Sets the software request flag |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write phase, 0 = read phase |
| mem_addr_o | output | AW | Access address |
| mem_word_o | output | 1 | Access is 16 bits |
| mem_wdata_o | output | 16 | Write data |
| mem_gnt_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 16 | Read data, valid in grant cycle |
| armed_o | output | 1 | Channel armed |
| sw_req_o | output | 1 | Software request flag |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
Two events can fall in the same cycle. A start is accepted, which clears the software flag, in the same cycle that `sw_req_set_i` pulses again. The bench provokes this by driving the set pulse in exactly the cycle after arming, while a flag is already pending. It judges the result by `sw_req_o` staying high after the block and by a fresh block starting at once when the channel is re-armed. Hardware trigger pulses are also injected in the middle of a block while grants stall at random. The count of written items must still equal the configured length.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_INC   = 2'd1,
    STEP_DEC   = 2'd2,
    STEP_HOLD3 = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    XM_SINGLE     = 2'd0,
    XM_BLOCK      = 2'd1,
    XM_RPT_SINGLE = 2'd2,
    XM_RPT_BLOCK  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } state_e;

  localparam int unsigned VLEN_BITS = 13;
  localparam int unsigned DW        = 16;
endpackage

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          restore_i,
  input  logic          step_en_i,
  input  logic          word_i,
  input  logic [1:0]    step_i,
  input  logic [AW-1:0] cfg_addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q, addr_q, delta;

  assign delta  = word_i ? AW'(2) : AW'(1);
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (arm_i) begin
      base_q <= cfg_addr_i;
      addr_q <= cfg_addr_i;
    end else if (restore_i) begin
      addr_q <= base_q;
    end else if (step_en_i) begin
      case (step_e'(step_i))
        STEP_INC: addr_q <= addr_q + delta;
        STEP_DEC: addr_q <= addr_q - delta;
        default:  addr_q <= addr_q;
      endcase
    end
  end

  p_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_en_i && !restore_i && !arm_i && step_i == STEP_INC)
      |-> addr_o == $past(addr_o) + $past(delta));
  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_en_i && !restore_i && !arm_i && step_i == STEP_DEC)
      |-> addr_o == $past(addr_o) - $past(delta));
endmodule

// File: rtl/dma_chan_len.sv
module dma_chan_len
  import dma_chan_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arm_i,
  input  logic                 restore_i,
  input  logic                 cap_i,
  input  logic                 dec_i,
  input  logic                 word_i,
  input  logic                 len8_i,
  input  logic [CW-1:0]        cfg_cnt_i,
  input  logic [VLEN_BITS-1:0] cap_data_i,
  output logic                 last_o
);
  logic [CW-1:0]        base_q, rem_q;
  logic [VLEN_BITS-1:0] vlen;

  always_comb begin
    if (word_i)      vlen = cap_data_i;
    else if (len8_i) vlen = {{(VLEN_BITS-8){1'b0}}, cap_data_i[7:0]};
    else             vlen = {{(VLEN_BITS-7){1'b0}}, cap_data_i[6:0]};
  end

  // count of items still to write, including the one in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      rem_q  <= '0;
    end else if (arm_i) begin
      base_q <= cfg_cnt_i;
      rem_q  <= cfg_cnt_i;
    end else if (restore_i) begin
      rem_q <= base_q;
    end else if (cap_i) begin
      rem_q <= CW'(vlen) + CW'(1);
    end else if (dec_i) begin
      rem_q <= rem_q - CW'(1);
    end
  end

  assign last_o = rem_q <= CW'(1);

  p_vlen_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && !arm_i && !restore_i && vlen == '0 |=> last_o);
  p_vlen_more_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && !arm_i && !restore_i && vlen != '0 |=> !last_o);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          trig_i,
  input  logic          sw_set_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic          cfg_word_i,
  input  logic          cfg_vlen_i,
  input  logic          cfg_len8_i,
  input  logic          cfg_irq_en_i,
  input  logic [1:0]    cfg_src_step_i,
  input  logic [1:0]    cfg_dst_step_i,
  input  logic          gnt_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          last_i,
  output logic          arm_o,
  output logic          restore_o,
  output logic          cap_o,
  output logic          dec_o,
  output logic          step_o,
  output logic          word_o,
  output logic          len8_o,
  output logic [1:0]    src_step_o,
  output logic [1:0]    dst_step_o,
  output logic          req_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          armed_o,
  output logic          sw_req_o,
  output logic          irq_o
);
  state_e     st_q, st_d;
  xfer_mode_e mode_q;
  logic       word_q, vlen_q, len8_q, irq_en_q;
  logic [1:0] src_step_q, dst_step_q;
  logic       armed_q, sw_q, first_q, irq_q;
  logic [DW-1:0] data_q;
  logic       start, rd_done, wr_done, fin, is_block, is_rpt;

  assign is_block = mode_q[0];
  assign is_rpt   = mode_q[1];
  assign arm_o    = arm_i && st_q == ST_IDLE;
  assign start    = st_q == ST_IDLE && armed_q && !arm_i && (trig_i || sw_q);
  assign rd_done  = st_q == ST_READ && gnt_i;
  assign wr_done  = st_q == ST_WRITE && gnt_i;
  assign fin      = wr_done && last_i;

  assign restore_o  = fin && is_rpt;
  assign cap_o      = rd_done && first_q && vlen_q;
  assign dec_o      = wr_done && !last_i;
  assign step_o     = wr_done;
  assign word_o     = word_q;
  assign len8_o     = len8_q;
  assign src_step_o = src_step_q;
  assign dst_step_o = dst_step_q;
  assign req_o      = st_q != ST_IDLE;
  assign we_o       = st_q == ST_WRITE;
  assign wdata_o    = data_q;
  assign armed_o    = armed_q;
  assign sw_req_o   = sw_q;
  assign irq_o      = irq_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_READ;
      ST_READ:  if (gnt_i) st_d = ST_WRITE;
      ST_WRITE: if (gnt_i) st_d = (!last_i && is_block) ? ST_READ : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mode_q     <= XM_SINGLE;
      word_q     <= 1'b0;
      vlen_q     <= 1'b0;
      len8_q     <= 1'b0;
      irq_en_q   <= 1'b0;
      src_step_q <= '0;
      dst_step_q <= '0;
      armed_q    <= 1'b0;
      sw_q       <= 1'b0;
      first_q    <= 1'b0;
      irq_q      <= 1'b0;
      data_q     <= '0;
    end else begin
      st_q  <= st_d;
      irq_q <= fin && irq_en_q;
      if (arm_o) begin
        mode_q     <= xfer_mode_e'(cfg_mode_i);
        word_q     <= cfg_word_i;
        vlen_q     <= cfg_vlen_i;
        len8_q     <= cfg_len8_i;
        irq_en_q   <= cfg_irq_en_i;
        src_step_q <= cfg_src_step_i;
        dst_step_q <= cfg_dst_step_i;
      end
      if (arm_o)                armed_q <= 1'b1;
      else if (fin && !is_rpt)  armed_q <= 1'b0;
      if (sw_set_i)             sw_q <= 1'b1;
      else if (start)           sw_q <= 1'b0;
      if (arm_o || restore_o)   first_q <= 1'b1;
      else if (rd_done)         first_q <= 1'b0;
      if (rd_done)
        data_q <= word_q ? rdata_i : {8'h00, rdata_i[7:0]};
    end
  end

  p_req_armed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> armed_q);
  p_write_after_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_o) |-> $past(req_o && !we_o && gnt_i));
  p_disarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_q) |-> $past(wr_done && !is_rpt));
  p_irq_after_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(req_o && we_o && gnt_i));
  p_sw_clear_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_q) |-> st_q == ST_READ);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic [CW-1:0] cfg_len_i,
  input  logic [1:0]    cfg_src_step_i,
  input  logic [1:0]    cfg_dst_step_i,
  input  logic          cfg_word_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic          cfg_vlen_i,
  input  logic          cfg_len8_i,
  input  logic          cfg_irq_en_i,
  input  logic          arm_i,
  input  logic          trig_i,
  input  logic          sw_req_set_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_word_o,
  output logic [15:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic [15:0]   mem_rdata_i,
  output logic          armed_o,
  output logic          sw_req_o,
  output logic          irq_o
);
  localparam int unsigned NPTR = 2;  // 0 = source, 1 = destination

  logic          arm_ok, restore, cap, dec, step_en, word, len8, last;
  logic [1:0]    src_step, dst_step;
  logic [1:0]    ptr_step [NPTR];
  logic [AW-1:0] ptr_cfg  [NPTR];
  logic [AW-1:0] ptr_addr [NPTR];

  assign ptr_step[0] = src_step;
  assign ptr_step[1] = dst_step;
  assign ptr_cfg[0]  = cfg_src_i;
  assign ptr_cfg[1]  = cfg_dst_i;

  dma_chan_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .arm_i          (arm_i),
    .trig_i         (trig_i),
    .sw_set_i       (sw_req_set_i),
    .cfg_mode_i     (cfg_mode_i),
    .cfg_word_i     (cfg_word_i),
    .cfg_vlen_i     (cfg_vlen_i),
    .cfg_len8_i     (cfg_len8_i),
    .cfg_irq_en_i   (cfg_irq_en_i),
    .cfg_src_step_i (cfg_src_step_i),
    .cfg_dst_step_i (cfg_dst_step_i),
    .gnt_i          (mem_gnt_i),
    .rdata_i        (mem_rdata_i),
    .last_i         (last),
    .arm_o          (arm_ok),
    .restore_o      (restore),
    .cap_o          (cap),
    .dec_o          (dec),
    .step_o         (step_en),
    .word_o         (word),
    .len8_o         (len8),
    .src_step_o     (src_step),
    .dst_step_o     (dst_step),
    .req_o          (mem_req_o),
    .we_o           (mem_we_o),
    .wdata_o        (mem_wdata_o),
    .armed_o        (armed_o),
    .sw_req_o       (sw_req_o),
    .irq_o          (irq_o)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_chan_addr #(.AW(AW)) u_addr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .arm_i      (arm_ok),
      .restore_i  (restore),
      .step_en_i  (step_en),
      .word_i     (word),
      .step_i     (ptr_step[g]),
      .cfg_addr_i (ptr_cfg[g]),
      .addr_o     (ptr_addr[g])
    );
  end

  dma_chan_len #(.CW(CW)) u_len (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_ok),
    .restore_i  (restore),
    .cap_i      (cap),
    .dec_i      (dec),
    .word_i     (word),
    .len8_i     (len8),
    .cfg_cnt_i  (cfg_len_i),
    .cap_data_i (mem_rdata_i[VLEN_BITS-1:0]),
    .last_o     (last)
  );

  assign mem_addr_o = mem_we_o ? ptr_addr[1] : ptr_addr[0];
  assign mem_word_o = word;

  p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o));
endmodule

// File: tb/sim_dma_chan.sv
module sim_dma_chan;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int CW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_P/2) clk_i = ~clk_i;

  logic [AW-1:0] cfg_src, cfg_dst, mem_addr;
  logic [CW-1:0] cfg_len;
  logic [1:0]    cfg_ss, cfg_ds, cfg_mode;
  logic          cfg_word, cfg_vlen, cfg_len8, cfg_irq;
  logic          arm, trig, sw_set, gnt;
  logic          mem_req, mem_we, mem_word, armed, sw_req, irq;
  logic [15:0]   mem_wdata, mem_rdata;

  dma_chan #(.AW(AW), .CW(CW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .cfg_len_i(cfg_len),
    .cfg_src_step_i(cfg_ss), .cfg_dst_step_i(cfg_ds), .cfg_word_i(cfg_word),
    .cfg_mode_i(cfg_mode), .cfg_vlen_i(cfg_vlen), .cfg_len8_i(cfg_len8),
    .cfg_irq_en_i(cfg_irq), .arm_i(arm), .trig_i(trig), .sw_req_set_i(sw_set),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_word_o(mem_word), .mem_wdata_o(mem_wdata), .mem_gnt_i(gnt),
    .mem_rdata_i(mem_rdata), .armed_o(armed), .sw_req_o(sw_req), .irq_o(irq)
  );

  logic [7:0]  bmem [256];
  logic [7:0]  orig [256];
  logic [7:0]  wa   [512];
  logic [15:0] wd   [512];
  logic        ww   [512];
  int wr_cnt = 0, irq_cnt = 0, irq_bad = 0;
  int errs = 0, checks = 0;
  bit stall_en = 0, prev_wr = 0, done = 0;

  always_comb mem_rdata = {bmem[8'(mem_addr + 8'd1)], bmem[mem_addr]};

  // grant driver and transaction log, all away from the rising edge
  always @(negedge clk_i) begin
    if (irq) begin
      irq_cnt++;
      if (!prev_wr) irq_bad++;
    end
    gnt = stall_en ? 1'($urandom_range(0, 1)) : 1'b1;
    prev_wr = mem_req && mem_we && gnt;
    if (prev_wr) begin
      wa[wr_cnt % 512] = mem_addr;
      wd[wr_cnt % 512] = mem_wdata;
      ww[wr_cnt % 512] = mem_word;
      bmem[mem_addr] = mem_wdata[7:0];
      if (mem_word) bmem[8'(mem_addr + 8'd1)] = mem_wdata[15:8];
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  task automatic fill();
    for (int i = 0; i < 256; i++) begin
      bmem[i] = pat(i);
      orig[i] = pat(i);
    end
  endtask

  task automatic put(input int a, input logic [7:0] v);
    bmem[a] = v;
    orig[a] = v;
  endtask

  task automatic arm_cfg(input int s, input int d, input int n, input int ss, input int ds,
                         input bit w, input int md, input bit vl, input bit l8, input bit ie);
    @(negedge clk_i);
    cfg_src = AW'(s); cfg_dst = AW'(d); cfg_len = CW'(n);
    cfg_ss = 2'(ss); cfg_ds = 2'(ds); cfg_word = w; cfg_mode = 2'(md);
    cfg_vlen = vl; cfg_len8 = l8; cfg_irq = ie;
    arm = 1'b1;
    @(negedge clk_i);
    arm = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk_i); trig = 1'b1;
    @(negedge clk_i); trig = 1'b0;
  endtask

  task automatic wait_wr(input int n);
    for (int i = 0; i < 3000; i++) begin
      if (wr_cnt >= n) break;
      @(negedge clk_i);
    end
    repeat (8) @(negedge clk_i);
  endtask

  function automatic int stp(input int code);
    return code == 1 ? 1 : (code == 2 ? -1 : 0);
  endfunction

  // compare the write log against the arithmetic model
  task automatic check_run(input int n, input int s, input int ss, input int d, input int ds,
                           input bit w, input string tag);
    int bad = 0;
    int sz = w ? 2 : 1;
    for (int k = 0; k < n; k++) begin
      int ea = (d + k * stp(ds) * sz) & 255;
      int sa = (s + k * stp(ss) * sz) & 255;
      logic [15:0] ed = w ? {orig[(sa + 1) & 255], orig[sa]} : {8'h00, orig[sa]};
      if (wa[k] !== 8'(ea) || wd[k] !== ed || ww[k] !== w) bad++;
    end
    chk(bad == 0 && wr_cnt == n, tag, wr_cnt * 1000 + bad, n * 1000);
  endtask

  task automatic clr();
    @(negedge clk_i);
    wr_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int ic;
    cfg_src = '0; cfg_dst = '0; cfg_len = '0; cfg_ss = '0; cfg_ds = '0;
    cfg_word = 0; cfg_mode = 0; cfg_vlen = 0; cfg_len8 = 0; cfg_irq = 0;
    arm = 0; trig = 0; sw_set = 0;
    fill();
    repeat (3) @(negedge clk_i);
    chk(!armed && !mem_req && !irq && !sw_req, "R1 reset outputs",
        {armed, mem_req, irq, sw_req}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2: trigger while disarmed
    pulse_trig();
    repeat (20) @(negedge clk_i);
    chk(wr_cnt == 0 && !armed, "R2 trigger while disarmed", wr_cnt, 0);

    // R3 R4 R5 R7 R8: sweep of step codes and item size in block mode
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int w = 0; w < 2; w++) begin
          fill(); clr();
          stall_en = (ss == 2);
          ic = irq_cnt;
          arm_cfg(32, 160, 4, ss, ds, w[0], 1, 0, 0, 1);
          chk(armed, "R2 armed after arm", armed, 1);
          pulse_trig();
          wait_wr(4);
          check_run(4, 32, ss, 160, ds, w[0], "R5 R3 R4 block sweep");
          chk(!armed && irq_cnt == ic + 1, "R8 disarm and R10 irq", irq_cnt - ic, 1);
        end
    stall_en = 0;

    // R5: code 3 holds the address
    fill(); clr();
    arm_cfg(16, 200, 3, 3, 3, 0, 1, 0, 0, 1);
    pulse_trig(); wait_wr(3);
    check_run(3, 16, 0, 200, 0, 0, "R5 step code 3 holds");

    // R6: single mode, one item per start
    fill(); clr();
    arm_cfg(8, 100, 3, 1, 1, 0, 0, 0, 0, 1);
    ic = irq_cnt;
    pulse_trig(); wait_wr(1);
    chk(wr_cnt == 1 && armed, "R6 single moves one item", wr_cnt, 1);
    pulse_trig(); wait_wr(2);
    pulse_trig(); wait_wr(3);
    check_run(3, 8, 1, 100, 1, 0, "R6 single sequence");
    chk(!armed && irq_cnt == ic + 1, "R8 single disarm", irq_cnt - ic, 1);

    // R2: trigger after disarm has no effect
    pulse_trig(); repeat (20) @(negedge clk_i);
    chk(wr_cnt == 3, "R2 trigger after disarm", wr_cnt, 3);

    // R8: count of zero moves one item
    fill(); clr();
    arm_cfg(40, 120, 0, 1, 1, 1, 1, 0, 0, 1);
    pulse_trig(); wait_wr(1); repeat (20) @(negedge clk_i);
    check_run(1, 40, 1, 120, 1, 1, "R8 zero count moves one");

    // R9: repeated block restores addresses
    fill(); clr();
    ic = irq_cnt;
    arm_cfg(48, 140, 2, 1, 1, 0, 3, 0, 0, 1);
    pulse_trig(); wait_wr(2);
    chk(armed && irq_cnt == ic + 1, "R9 repeated block stays armed", armed, 1);
    pulse_trig(); wait_wr(4);
    chk(wr_cnt == 4 && wa[2] == 8'd140 && wa[3] == 8'd141, "R9 restart at base",
        wa[2], 140);

    // R9 R6: repeated single
    fill(); clr();
    arm_cfg(48, 150, 2, 1, 2, 0, 2, 0, 0, 1);
    repeat (3) begin pulse_trig(); wait_wr(wr_cnt + 1); end
    chk(wr_cnt == 3 && wa[2] == 8'd150 && wa[1] == 8'd149 && armed,
        "R9 repeated single restart", wa[2], 150);

    // R7: extra triggers mid-block ignored, with stalls
    fill(); clr();
    stall_en = 1;
    arm_cfg(0, 128, 5, 1, 1, 0, 1, 0, 0, 1);
    pulse_trig(); repeat (2) @(negedge clk_i);
    pulse_trig(); pulse_trig();
    wait_wr(5); repeat (40) @(negedge clk_i);
    check_run(5, 0, 1, 128, 1, 0, "R7 mid-block triggers ignored");
    stall_en = 0;

    // R10: interrupt masked
    fill(); clr();
    ic = irq_cnt;
    arm_cfg(0, 128, 2, 1, 1, 0, 1, 0, 0, 0);
    pulse_trig(); wait_wr(2);
    chk(irq_cnt == ic && !armed, "R10 masked irq", irq_cnt - ic, 0);

    // R11 R12: byte length, 7-bit width, 0x83 -> 3
    fill(); clr();
    put(10, 8'h83);
    arm_cfg(10, 180, 77, 1, 1, 0, 1, 1, 0, 1);
    pulse_trig(); wait_wr(4); repeat (20) @(negedge clk_i);
    check_run(4, 10, 1, 180, 1, 0, "R12 7-bit length");

    // R12: same byte, 8-bit width -> 131 + 1 items
    fill(); clr();
    put(0, 8'h83);
    arm_cfg(0, 255, 9, 1, 2, 0, 1, 1, 1, 1);
    pulse_trig(); wait_wr(132); repeat (20) @(negedge clk_i);
    chk(wr_cnt == 132 && wd[0] == 16'h0083, "R12 8-bit length", wr_cnt, 132);

    // R11: length 0 by 7-bit mask of 0x80 moves only the length item
    fill(); clr();
    put(20, 8'h80);
    arm_cfg(20, 90, 9, 1, 1, 0, 1, 1, 0, 1);
    pulse_trig(); wait_wr(1); repeat (20) @(negedge clk_i);
    check_run(1, 20, 1, 90, 1, 0, "R11 zero length");

    // R11: word length uses bits 12:0, 0xE004 -> 4
    fill(); clr();
    put(60, 8'h04); put(61, 8'hE0);
    arm_cfg(60, 200, 1, 1, 1, 1, 1, 1, 0, 1);
    pulse_trig(); wait_wr(5); repeat (20) @(negedge clk_i);
    check_run(5, 60, 1, 200, 1, 1, "R11 word length");

    // R11 R6: variable length in single mode, one item per start
    fill(); clr();
    put(30, 8'h01);
    arm_cfg(30, 70, 50, 1, 1, 0, 0, 1, 1, 1);
    pulse_trig(); wait_wr(1);
    chk(armed && wr_cnt == 1, "R11 single first item", wr_cnt, 1);
    pulse_trig(); wait_wr(2);
    check_run(2, 30, 1, 70, 1, 0, "R11 single vlen done");
    chk(!armed, "R11 single vlen disarm", armed, 0);

    // R13: software flag pending while disarmed
    fill(); clr();
    @(negedge clk_i); sw_set = 1;
    @(negedge clk_i); sw_set = 0;
    repeat (10) @(negedge clk_i);
    chk(sw_req && wr_cnt == 0, "R13 flag pending while disarmed", sw_req, 1);
    arm_cfg(0, 100, 2, 1, 1, 0, 1, 0, 0, 1);
    wait_wr(2);
    check_run(2, 0, 1, 100, 1, 0, "R13 software start");
    chk(!sw_req, "R13 flag cleared on accept", sw_req, 0);

    // R13: set in the accept cycle stays set
    fill(); clr();
    @(negedge clk_i); sw_set = 1;
    @(negedge clk_i); sw_set = 0;
    arm_cfg(0, 100, 2, 1, 1, 0, 1, 0, 0, 1);
    sw_set = 1;
    @(negedge clk_i); sw_set = 0;
    wait_wr(2);
    chk(sw_req && wr_cnt == 2 && !armed, "R13 set during accept kept", sw_req, 1);
    clr();
    arm_cfg(0, 110, 2, 1, 1, 0, 1, 0, 0, 1);
    wait_wr(2);
    chk(!sw_req && wr_cnt == 2 && wa[0] == 8'd110, "R13 pending flag starts", wr_cnt, 2);

    chk(irq_bad == 0, "R10 irq only after write grant", irq_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule